// File: doc/BRIEF.md
# Reset Hold and Release Timer

This block sits between the raw reset sources of a small processor and its core. Any reset source holds the core in reset. The hold lasts while the source is active and then for a fixed number of internal oscillator ticks after the source goes away, so that the supply and the clock can settle. The wait after a power-on is long and the wait after any later reset is short. A sticky flag tells the two cases apart. Only power-on clears it, and it is set once the first wait completes.

There are four reset sources. Power-on is an asynchronous active-low input. The external reset pin holds the core while its level is low, and the count starts only once the pin is back high. The watchdog request and the pin-change wake request each hold the core while they are set. The block records which source caused the last reset as a 2-bit code, which software reads after the core leaves reset. Both wait lengths are tick counts set by parameters: `LONG_TICKS` for the power-on wait (about 18 ms) and `SHORT_TICKS` for the later-reset wait (about 10 µs).

Top module: `rst_hold_timer`

## Requirements
- R1: After `por_n` returns high, `core_rst` stays 1 for exactly `LONG_TICKS` clock edges on which `tick` is 1, then drops to 0.
- R2: Once the core has left reset since the last power-on, releasing any other source keeps `core_rst` at 1 for exactly `SHORT_TICKS` tick edges, then drops it to 0.
- R3: `core_rst` is 1 on the cycle after any edge at which `pin_lvl` is 0, `wdt_req` is 1 or `wake_req` is 1.
- R4: Clock edges with `tick` at 0 do not advance the release count.
- R5: `cause` encodes the last source as 0 for power-on, 1 for pin low, 2 for watchdog and 3 for wake. It is updated while a source is active and holds its value after release.
- R6: When sources are active together, the pin takes priority over the watchdog, and the watchdog over the wake request.
- R7: A source that becomes active while the release count is running cancels that count, and the full short count starts again from zero after the source is released.
- R8: The short-wait flag is cleared only by `por_n`. A new power-on brings back the long wait and cause 0.
- R9: While `por_n` is low, `core_rst` is 1 and `cause` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| tick | input | 1 | Internal oscillator tick strobe, one clock wide |
| pin_lvl | input | 1 | External reset pin level, low requests reset |
| wdt_req | input | 1 | Watchdog timeout reset request |
| wake_req | input | 1 | Pin-change wake-up reset request |
| core_rst | output | 1 | Reset held on the processor core, active high |
| cause | output | 2 | Code of the last reset cause |

## Verification
On every cycle the assertions check the following:
- an active source puts the core back into reset (R3);
- the count never moves without a tick (R4);
- the counter stays below its limit;
- the core leaves reset only when the counter reports done (R1, R2);
- the cause code holds still while no source is active (R5);
- the pin wins the priority (R6);
- the short-wait flag never falls except through power-on (R8).

The exact wait lengths need the bench's scenarios, because a property cannot see the tick totals. The same holds for the choice between the long and the short wait, the restart of the count after a mid-count source (R7), and the codes recorded for each source in turn.

// File: rtl/rst_hold_pkg.sv
package rst_hold_pkg;

    typedef enum logic [1:0] {
        CAUSE_POR  = 2'd0,
        CAUSE_PIN  = 2'd1,
        CAUSE_WDT  = 2'd2,
        CAUSE_WAKE = 2'd3
    } cause_e;

    typedef struct packed {
        logic   running;   // core released
        logic   powered;   // first release since power-on done
        cause_e cause;
    } ctl_t;

endpackage

// File: rtl/rst_src_enc.sv
module rst_src_enc
    import rst_hold_pkg::*;
(
    input  logic   pin_lvl,
    input  logic   wdt_req,
    input  logic   wake_req,
    output logic   any_src,
    output cause_e src_code
);

    // Fixed priority: pin, then watchdog, then wake request.
    always_comb begin
        any_src  = !pin_lvl || wdt_req || wake_req;
        src_code = CAUSE_WAKE;
        if (!pin_lvl) begin
            src_code = CAUSE_PIN;
        end else if (wdt_req) begin
            src_code = CAUSE_WDT;
        end
    end

endmodule

// File: rtl/rst_delay_cnt.sv
module rst_delay_cnt #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          por_n,
    input  logic          clr,
    input  logic          en,
    input  logic [CW-1:0] limit,
    output logic          done
);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        done  = en && !clr && (cnt_q == limit - 1'b1);
        cnt_d = cnt_q;
        if (clr || done) begin
            cnt_d = '0;
        end else if (en) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // R4: count frozen on edges without a tick
    a_r4_no_tick_no_count: assert property (@(posedge clk) disable iff (!por_n)
        (!en && !clr) |=> $stable(cnt_q));

    // R2: count never reaches its limit
    a_r2_below_limit: assert property (@(posedge clk) disable iff (!por_n)
        cnt_q < limit);

endmodule

// File: rtl/rst_hold_timer.sv
module rst_hold_timer
    import rst_hold_pkg::*;
#(
    parameter int LONG_TICKS  = 18000,
    parameter int SHORT_TICKS = 10
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       tick,
    input  logic       pin_lvl,
    input  logic       wdt_req,
    input  logic       wake_req,
    output logic       core_rst,
    output logic [1:0] cause
);

    localparam int CW = $clog2(LONG_TICKS + 1);
    localparam logic [CW-1:0] LONG_LIM  = CW'(LONG_TICKS);
    localparam logic [CW-1:0] SHORT_LIM = CW'(SHORT_TICKS);

    ctl_t   ctl_d, ctl_q;
    logic   any_src;
    cause_e src_code;
    logic   cnt_clr, cnt_en, cnt_done;
    logic [CW-1:0] lim;

    rst_src_enc u_enc (
        .pin_lvl  (pin_lvl),
        .wdt_req  (wdt_req),
        .wake_req (wake_req),
        .any_src  (any_src),
        .src_code (src_code)
    );

    rst_delay_cnt #(.CW(CW)) u_cnt (
        .clk   (clk),
        .por_n (por_n),
        .clr   (cnt_clr),
        .en    (cnt_en),
        .limit (lim),
        .done  (cnt_done)
    );

    always_comb begin
        lim     = ctl_q.powered ? SHORT_LIM : LONG_LIM;
        cnt_clr = any_src || ctl_q.running;
        cnt_en  = tick;
        ctl_d   = ctl_q;
        if (any_src) begin
            ctl_d.running = 1'b0;
            ctl_d.cause   = src_code;
        end else if (!ctl_q.running && cnt_done) begin
            ctl_d.running = 1'b1;
            ctl_d.powered = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            ctl_q <= '{running: 1'b0, powered: 1'b0, cause: CAUSE_POR};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign core_rst = !ctl_q.running;
    assign cause    = ctl_q.cause;

    // R3: active source forces the core into reset
    a_r3_src_holds: assert property (@(posedge clk) disable iff (!por_n)
        any_src |=> core_rst);

    // R1, R2: release only when the counter reports done
    a_r1_release_on_done: assert property (@(posedge clk) disable iff (!por_n)
        $rose(ctl_q.running) |-> $past(cnt_done));

    // R5: cause code holds while no source is active
    a_r5_cause_held: assert property (@(posedge clk) disable iff (!por_n)
        !any_src |=> $stable(cause));

    // R6: pin has top priority
    a_r6_pin_first: assert property (@(posedge clk) disable iff (!por_n)
        !pin_lvl |=> (cause == 2'd1));

    // R8: short-wait flag never falls without power-on
    a_r8_powered_sticky: assert property (@(posedge clk) disable iff (!por_n)
        ctl_q.powered |=> ctl_q.powered);

endmodule

// File: tb/rst_hold_timer_tb.sv
module rst_hold_timer_tb;

    localparam int LONG  = 24;
    localparam int SHORT = 5;
    localparam int NV    = 6;
    // vector table: source (1 pin, 2 watchdog, 3 wake), hold edges, expected cause
    localparam int V_SRC  [NV] = '{1, 2, 3, 1, 3, 2};
    localparam int V_HOLD [NV] = '{3, 1, 2, 5, 1, 4};
    localparam int V_CAUSE[NV] = '{1, 2, 3, 1, 3, 2};

    logic clk = 1'b0;
    logic por_n, tick, pin_lvl, wdt_req, wake_req;
    logic core_rst;
    logic [1:0] cause;
    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #4 clk = !clk;

    rst_hold_timer #(.LONG_TICKS(LONG), .SHORT_TICKS(SHORT)) u_dut (
        .clk      (clk),
        .por_n    (por_n),
        .tick     (tick),
        .pin_lvl  (pin_lvl),
        .wdt_req  (wdt_req),
        .wake_req (wake_req),
        .core_rst (core_rst),
        .cause    (cause)
    );

    task automatic chk(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic edges(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic apply(input int s);
        pin_lvl  = (s == 1) ? 1'b0 : 1'b1;
        wdt_req  = (s == 2);
        wake_req = (s == 3);
    endtask

    // Count release edges: still held one edge short, free on the last.
    task automatic release_chk(input int lim, input string tag);
        apply(0);
        for (int i = 1; i <= lim; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (i == lim - 1) chk(core_rst, 1, {tag, " held before limit"});
            if (i == lim)     chk(core_rst, 0, {tag, " released at limit"});
        end
    endtask

    initial begin
        por_n = 1'b0; tick = 1'b1; apply(0);
        edges(3);
        chk(core_rst, 1, "R9 reset core_rst");
        chk(cause, 0, "R9 reset cause");
        por_n = 1'b1;
        release_chk(LONG, "R1");
        chk(cause, 0, "R5 power-on cause");

        for (int v = 0; v < NV; v++) begin
            apply(V_SRC[v]);
            edges(V_HOLD[v]);
            chk(core_rst, 1, "R3 held while source active");
            release_chk(SHORT, "R2");
            chk(cause, V_CAUSE[v], "R5 cause after release");
        end

        // R4: tick-less edges do not count
        apply(1); edges(2); apply(0);
        tick = 1'b0; edges(10);
        chk(core_rst, 1, "R4 no count without tick");
        tick = 1'b1;
        release_chk(SHORT, "R4");

        // R7: source mid-count restarts the full count
        apply(1); edges(2); apply(0);
        edges(SHORT - 1);
        chk(core_rst, 1, "R7 still counting");
        apply(2); edges(1);
        release_chk(SHORT, "R7");
        chk(cause, 2, "R7 cause watchdog");

        // R6: priorities
        pin_lvl = 1'b0; wdt_req = 1'b1; wake_req = 1'b1; edges(1);
        chk(cause, 1, "R6 pin over watchdog");
        pin_lvl = 1'b1; edges(1);
        chk(cause, 2, "R6 watchdog over wake");
        release_chk(SHORT, "R6");

        // R8: a new power-on returns the long wait
        por_n = 1'b0; edges(2);
        chk(cause, 0, "R8 cause after power-on");
        por_n = 1'b1;
        release_chk(LONG, "R8");

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #400000;
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule